// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Overflow Interrupt

This block is an 8-bit up-counter for a small controller's I/O space. A 3-bit select field in its control register picks what advances the count. The count can be stopped, or it can step on every system clock. It can also step once per 8, 64, 256 or 1024 clocks, using taps of a free-running prescaler. The last two choices count falling or rising edges of an external pin, which first passes through a two-flop synchronizer.

When the count wraps from its maximum value back to zero, an overflow flag is latched. An interrupt request is driven while all of the following hold:
- the overflow flag is set;
- its mask bit is set;
- the global interrupt enable from the status register is high;
- the pipeline's interrupt-disable input is low.

Software clears the flag by writing a one to it. The pipeline clears it by acknowledging the interrupt. All four registers can be written and read through one register port.

Top module: `tmr8_ovf_irq`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_req` is low.
- R2: With select value 0, the count does not change.
- R3: With select value 1, the count increases by one on every clock edge.
- R4: Select values 2, 3, 4 and 5 advance the count exactly once in every 8, 64, 256 and 1024 consecutive clock edges respectively.
- R5: With select value 6, the count advances once for each falling edge of `ext_pin`, and rising edges do not advance it.
- R6: With select value 7, the count advances once for each rising edge of `ext_pin`.
- R7: A write to the count register (address 1) loads the written value on that edge. The write takes priority over a count step in the same cycle.
- R8: A step from 255 to 0 sets the overflow flag, which reads as bit 1 of the flag register (address 2).
- R9: Writing the flag register with bit 1 set clears the flag. Writing it with bit 1 clear has no effect. A pulse on `irq_ack` also clears the flag. A new overflow in the same cycle wins over any clear.
- R10: `irq_req` is high exactly when the flag is set, the mask register (address 3) bit 1 is set, `glb_int_en` is high and `irq_disable` is low.
- R11: The control register (address 0) holds the select value in bits 2:0 and reads it back there, with the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 flag, 3 mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ext_pin | input | 1 | Asynchronous external count input |
| glb_int_en | input | 1 | Global interrupt enable (status bit 7) |
| irq_disable | input | 1 | Pipeline interrupt suppression |
| irq_ack | input | 1 | Interrupt accepted; clears the flag |
| irq_req | output | 1 | Overflow interrupt request |

## Verification
Each register write takes effect on the edge that samples it, and reads are combinational, so the bench drives each write at a falling edge and reads back at the next falling edge.

A new select value first steers the count on the edge after the write. The count window therefore runs from the edge that follows the select write to the edge of the write that stops it. Each window is a multiple of the prescale ratio, so the expected step count does not depend on the prescaler's phase.

A pin edge reaches the count three edges after it occurs: two synchronizer flops plus the edge detector's history flop. The bench holds each pin level for at least three cycles and waits six cycles before it reads.

`irq_req` follows its inputs combinationally, so it is checked one delta after each input change.

// File: rtl/tmr_pkg.sv
// Shared definitions for the prescaled timer: register addresses,
// clock-select codes and prescaler tap widths.
package tmr_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_FLAG  = 2'd2,
        RA_MASK  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_SYS      = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    // Bit position of the overflow flag / mask inside their registers.
    localparam int OVF_BIT = 1;
    localparam int NUM_TAPS = 4;

    // Low-order prescaler bits that must be all ones for tap i to fire.
    function automatic int tap_bits(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Free-running prescaler. Each tap output is a one-cycle enable that fires
// once every 2**tap_bits(i) clocks. Assumes PW >= the widest tap.
module tmr_prescaler #(
    parameter int PW = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [tmr_pkg::NUM_TAPS-1:0] tap_en
);
    logic [PW-1:0] div_q;

    // Advance the divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < tmr_pkg::NUM_TAPS; i++) begin : g_tap
        localparam int B = tmr_pkg::tap_bits(i);
        assign tap_en[i] = &div_q[B-1:0];
    end
endmodule

// File: rtl/tmr_edge_sync.sv
// Synchronizes an asynchronous pin with SYNC_STAGES flops and flags its
// rising and falling edges for one cycle each. The edges appear one cycle
// after the synchronized level changes.
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] sh_q;

    // Shift the pin through the synchronizer and a history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
    end

    assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];
endmodule

// File: rtl/tmr_core.sv
// Holds the control, count, flag and mask registers and their read mux.
// Assumes W >= 3. A count write beats a step. A new overflow beats a flag clear.
module tmr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic         tick,
    input  logic         irq_ack,
    output logic [2:0]   sel_o,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         mask_o,
    output logic [W-1:0] reg_rdata
);
    import tmr_pkg::*;

    logic cnt_wr, ovf, flag_clr;

    assign cnt_wr   = reg_wr && (reg_addr == RA_COUNT);
    assign ovf      = tick && (count_o == '1) && !cnt_wr;
    assign flag_clr = irq_ack ||
                      (reg_wr && (reg_addr == RA_FLAG) && reg_wdata[OVF_BIT]);

    // Register updates: select, count, overflow flag, mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o   <= '0;
            count_o <= '0;
            flag_o  <= 1'b0;
            mask_o  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == RA_CTRL)) sel_o <= reg_wdata[2:0];
            if (cnt_wr)    count_o <= reg_wdata;
            else if (tick) count_o <= count_o + 1'b1;
            if (ovf)           flag_o <= 1'b1;
            else if (flag_clr) flag_o <= 1'b0;
            if (reg_wr && (reg_addr == RA_MASK)) mask_o <= reg_wdata[OVF_BIT];
        end
    end

    // Read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata[2:0]     = sel_o;
            RA_COUNT: reg_rdata          = count_o;
            RA_FLAG:  reg_rdata[OVF_BIT] = flag_o;
            default:  reg_rdata[OVF_BIT] = mask_o;
        endcase
    end
endmodule

// File: rtl/tmr8_ovf_irq.sv
// Top of the prescaled timer. It picks the step source from the select
// field and gates the overflow request. Assumes a synchronous reset.
module tmr8_ovf_irq #(
    parameter int W           = 8,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         ext_pin,
    input  logic         glb_int_en,
    input  logic         irq_disable,
    input  logic         irq_ack,
    output logic         irq_req
);
    import tmr_pkg::*;

    logic [NUM_TAPS-1:0] tap_en;
    logic                pin_rise, pin_fall, tick;
    logic [2:0]          sel_q;
    logic [W-1:0]        count_q;
    logic                flag_q, mask_q;

    tmr_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tap_en(tap_en)
    );

    tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .rise(pin_rise), .fall(pin_fall)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tick(tick), .irq_ack(irq_ack),
        .sel_o(sel_q), .count_o(count_q), .flag_o(flag_q), .mask_o(mask_q),
        .reg_rdata(reg_rdata)
    );

    // Choose the step enable for the selected clock source.
    always_comb begin
        case (clk_sel_e'(sel_q))
            CS_SYS:      tick = 1'b1;
            CS_DIV8:     tick = tap_en[0];
            CS_DIV64:    tick = tap_en[1];
            CS_DIV256:   tick = tap_en[2];
            CS_DIV1024:  tick = tap_en[3];
            CS_EXT_FALL: tick = pin_fall;
            CS_EXT_RISE: tick = pin_rise;
            default:     tick = 1'b0;
        endcase
    end

    assign irq_req = flag_q & mask_q & glb_int_en & ~irq_disable;
endmodule

// File: rtl/tmr8_ovf_irq_chk.sv
// Property checker for the prescaled timer, bound into every instance.
module tmr8_ovf_irq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [2:0]   sel,
    input logic [W-1:0] count,
    input logic         tick,
    input logic         flag,
    input logic         mask,
    input logic         glb_int_en,
    input logic         irq_disable,
    input logic         irq_ack,
    input logic         irq_req
);
    logic cwr;
    assign cwr = reg_wr && (reg_addr == 2'd1);

    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0 && !cwr) |=> $stable(count));

    p_sys_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd1 && !cwr) |=> count == $past(count) + 1'b1);

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> count == $past(reg_wdata));

    p_wrap_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '1 && !cwr) |=> flag);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(tick && count == '1)) |=> !flag);

    p_req_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask || !glb_int_en || irq_disable || !flag) |-> !irq_req);
endmodule

bind tmr8_ovf_irq tmr8_ovf_irq_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sel(sel_q), .count(count_q), .tick(tick),
    .flag(flag_q), .mask(mask_q), .glb_int_en(glb_int_en),
    .irq_disable(irq_disable), .irq_ack(irq_ack), .irq_req(irq_req)
);

// File: tb/tb_tmr8_ovf_irq.sv
module tb_tmr8_ovf_irq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] win;
        logic [7:0]  exp;
    } vec_t;

    // select, window of counted edges, expected count afterwards
    localparam vec_t VEC [7] = '{
        '{3'd0, 32'd50,   8'd0},
        '{3'd1, 32'd37,   8'd37},
        '{3'd2, 32'd64,   8'd8},
        '{3'd3, 32'd640,  8'd10},
        '{3'd4, 32'd512,  8'd2},
        '{3'd5, 32'd2048, 8'd2},
        '{3'd1, 32'd300,  8'd44}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_pin = 1'b1;
    logic       glb_int_en = 1'b0;
    logic       irq_disable = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_ovf_irq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .glb_int_en(glb_int_en), .irq_disable(irq_disable),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; the write is taken at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b0; repeat (3) @(negedge clk);
            ext_pin = 1'b1; repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset reg", v, 8'h00);
        end
        check("R1 reset irq", {7'd0, irq_req}, 8'h00);

        // R2 R3 R4: table of count windows
        foreach (VEC[i]) begin
            wr(2'd1, 8'h00);
            wr(2'd0, {5'd0, VEC[i].sel});
            repeat (VEC[i].win - 1) @(negedge clk);
            wr(2'd0, 8'h00);
            rd(2'd1, v);
            check($sformatf("R2/R3/R4 sel %0d", VEC[i].sel), v, VEC[i].exp);
        end

        // R8: the 300-edge window wrapped once
        rd(2'd2, v);
        check("R8 flag after wrap", v, 8'h02);
        // R9: writing zero leaves the flag, writing bit 1 clears it
        wr(2'd2, 8'hFD);
        rd(2'd2, v);
        check("R9 write 0 no effect", v, 8'h02);
        wr(2'd2, 8'h02);
        rd(2'd2, v);
        check("R9 write 1 clears", v, 8'h00);

        // R11: control readback
        wr(2'd0, 8'hFD);
        rd(2'd0, v);
        check("R11 ctrl readback", v, 8'h05);
        wr(2'd0, 8'h00);

        // R5: falling edges only
        wr(2'd1, 8'h00);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h06);
        pin_pulses(3);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check("R5 falling edges", v, 8'd3);

        // R6: rising edges
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h07);
        pin_pulses(4);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check("R6 rising edges", v, 8'd4);

        // R7: a load wins over a step
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h5A);
        rd(2'd1, v);
        check("R7 load priority", v, 8'h5A);
        wr(2'd0, 8'h00);

        // R8 R10 R9: overflow, request gating, acknowledge
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check("R8 wrap to zero", v, 8'h00);
        rd(2'd2, v);
        check("R8 flag set", v, 8'h02);
        glb_int_en = 1'b1; #1;
        check("R10 masked", {7'd0, irq_req}, 8'h00);
        wr(2'd3, 8'h02);
        rd(2'd3, v);
        check("R10 mask readback", v, 8'h02);
        check("R10 request", {7'd0, irq_req}, 8'h01);
        irq_disable = 1'b1; #1;
        check("R10 disabled", {7'd0, irq_req}, 8'h00);
        irq_disable = 1'b0; glb_int_en = 1'b0; #1;
        check("R10 global off", {7'd0, irq_req}, 8'h00);
        glb_int_en = 1'b1; #1;
        check("R10 global on", {7'd0, irq_req}, 8'h01);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        rd(2'd2, v);
        check("R9 ack clears", v, 8'h00);
        check("R9 ack drops req", {7'd0, irq_req}, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule